// File: doc/BRIEF.md
# Two-Word Frequency Dither Controller

This block sits beside a phase-accumulator synthesizer that holds two frequency tuning registers and a select input. It gives frequency resolution finer than one tuning LSB. When an integer tuning word is loaded, the block writes that word to the lower register and the word plus one to the upper register. From then on it moves the select line between the two registers so that, over time, the share of cycles spent on the upper word equals a programmed fraction.

A first-order fractional accumulator makes the select pattern. On every update tick it adds the fraction, and the carry out of that addition drives the select line. This spreads the upper-word ticks as evenly as a binary fraction allows. A programmable prescaler sets how many master clock cycles separate two ticks.

A new word is applied in a fixed order. The select line drops to the lower register first. The block then waits for the synthesizer's select latency before it rewrites both registers. After the rewrite, the accumulator restarts from zero. This order keeps the synthesizer from running on a half-updated upper register.

Top module: `dither_ctrl`

## Requirements
- R1: After reset, `sel_hi` is 0, `word_lo` is 0, `word_hi` is 1 and `word_wr` is 0. Without any load, `sel_hi` stays 0.
- R2: A `load` sampled at a clock edge drives `sel_hi` to 0 at that same edge. `sel_hi` then stays 0 until the dither pattern restarts after the register write.
- R3: `word_wr` is a single-cycle pulse that rises SEL_LAT (default 6) edges after the edge that sampled `load`. In that cycle, `word_lo` equals the loaded integer and `word_hi` equals that integer plus one, modulo 2^TW_W. The words never change while `word_wr` is low.
- R4: With a captured prescale value P, the select line can change only once every P+1 cycles. The first update falls P+1 edges after the edge at which `word_wr` returns low.
- R5: With a captured fraction f and FRAC_W = N, the k-th update sets `sel_hi` to floor(k·f/2^N) − floor((k−1)·f/2^N). This is the carry of an accumulator that starts at zero.
- R6: Over any 2^N consecutive updates, `sel_hi` is 1 on exactly f of them.
- R7: f = 0 keeps `sel_hi` at 0 permanently. f = 2^N−1 leaves `sel_hi` at 0 on exactly one update out of every 2^N.
- R8: `tune_int`, `tune_frac` and `prescale` are sampled only on `load`. Changing them at any other time has no effect on `sel_hi`, `word_lo` or `word_hi`.
- R9: A `load` that arrives while an update is still in progress restarts the sequence. The write then follows SEL_LAT edges after the latest load and carries the latest values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Update strobe; samples the three tuning inputs |
| tune_int | input | TW_W | Integer tuning word (lower register value) |
| tune_frac | input | FRAC_W | Fractional part, in units of 2^-FRAC_W LSB |
| prescale | input | PRE_W | Update period minus one, in master clock cycles |
| word_lo | output | TW_W | Value for the lower tuning register |
| word_hi | output | TW_W | Value for the upper tuning register |
| word_wr | output | 1 | One-cycle pulse: write both tuning registers |
| sel_hi | output | 1 | Register select, 1 = upper register |

## Verification
A wrong accumulator residue shows up on `sel_hi` within one update tick, as a carry placed differently from the closed-form carry sequence. It also shifts the count of high ticks in a window of 2^N updates. A prescaler fault shows up as a `sel_hi` change in a cycle that is not a multiple of P+1 after the write. A sequencer fault shows up as a `word_wr` pulse one or more cycles away from SEL_LAT, or as `sel_hi` going high before the write completes. The bench sweeps every fraction of a 4-bit accumulator at several prescale values and compares every cycle with the arithmetic model. Each fault therefore appears within the first few updates after a load.

// File: rtl/dither_pkg.sv
`timescale 1ns/1ps
package dither_pkg;
  // Update sequencer states: normal dithering, select held low, register write
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dither_prescale.sv
`timescale 1ns/1ps
module dither_prescale #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] period_m1,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == period_m1);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: with a period above one cycle, two ticks never fall in adjacent cycles
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period_m1 != '0) |=> !tick);
endmodule

// File: rtl/dither_accum.sv
`timescale 1ns/1ps
module dither_accum #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [FRAC_W-1:0] frac,
  output logic              sel
);
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              sel_q, sel_d;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};
  assign sel = sel_q;

  always_comb begin
    acc_d = acc_q;
    sel_d = sel_q;
    if (clr) begin
      acc_d = '0;
      sel_d = 1'b0;
    end else if (tick) begin
      acc_d = sum[FRAC_W-1:0];
      sel_d = sum[FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sel_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      sel_q <= sel_d;
    end
  end

  // R4: select moves only on an update tick or a clear
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(sel_q));
  // R7: a zero fraction never produces a carry
  p_zero_frac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frac == '0 && !sel_q) |=> !sel_q);
endmodule

// File: rtl/dither_seq.sv
`timescale 1ns/1ps
module dither_seq
  import dither_pkg::*;
#(
  parameter int TW_W    = 32,
  parameter int FRAC_W  = 8,
  parameter int PRE_W   = 16,
  parameter int SEL_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TW_W-1:0]   int_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [PRE_W-1:0]  pre_in,
  output logic              run,
  output logic [FRAC_W-1:0] frac_q,
  output logic [PRE_W-1:0]  pre_q,
  output logic [TW_W-1:0]   word_lo,
  output logic [TW_W-1:0]   word_hi,
  output logic              word_wr
);
  localparam int HCNT_W = (SEL_LAT > 1) ? $clog2(SEL_LAT) : 1;
  localparam logic [HCNT_W-1:0] LAT_M1 = HCNT_W'(SEL_LAT - 1);

  seq_state_e        st_q, st_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [TW_W-1:0]   stg_q, stg_d;
  logic [FRAC_W-1:0] frac_d;
  logic [PRE_W-1:0]  pre_d;
  logic [TW_W-1:0]   lo_q, lo_d, hi_q, hi_d;
  logic              wr_q, wr_d;

  assign run     = (st_q == ST_RUN);
  assign word_lo = lo_q;
  assign word_hi = hi_q;
  assign word_wr = wr_q;

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    stg_d  = stg_q;
    frac_d = frac_q;
    pre_d  = pre_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    wr_d   = 1'b0;
    if (load) begin
      st_d   = ST_HOLD;
      hcnt_d = '0;
      stg_d  = int_in;
      frac_d = frac_in;
      pre_d  = pre_in;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          if (hcnt_q == LAT_M1) begin
            st_d = ST_WRITE;
            lo_d = stg_q;
            hi_d = stg_q + 1'b1;
            wr_d = 1'b1;
          end else begin
            hcnt_d = hcnt_q + 1'b1;
          end
        end
        ST_WRITE: st_d = ST_RUN;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      hcnt_q <= '0;
      stg_q  <= '0;
      frac_q <= '0;
      pre_q  <= '0;
      lo_q   <= '0;
      hi_q   <= TW_W'(1);
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
      stg_q  <= stg_d;
      frac_q <= frac_d;
      pre_q  <= pre_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      wr_q   <= wr_d;
    end
  end

  // R3: the write strobe lasts exactly one cycle
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |=> !word_wr);
  // R3: the write only follows a full hold interval
  p_wr_after_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_wr) |-> ($past(st_q) == ST_HOLD && $past(hcnt_q) == LAT_M1));
  // R9: every load (re)starts the hold interval
  p_load_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st_q == ST_HOLD && hcnt_q == '0));
endmodule

// File: rtl/dither_ctrl.sv
`timescale 1ns/1ps
module dither_ctrl #(
  parameter int TW_W    = 32,
  parameter int FRAC_W  = 8,
  parameter int PRE_W   = 16,
  parameter int SEL_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TW_W-1:0]   tune_int,
  input  logic [FRAC_W-1:0] tune_frac,
  input  logic [PRE_W-1:0]  prescale,
  output logic [TW_W-1:0]   word_lo,
  output logic [TW_W-1:0]   word_hi,
  output logic              word_wr,
  output logic              sel_hi
);
  logic              run;
  logic              tick;
  logic              acc_clr;
  logic [FRAC_W-1:0] frac_q;
  logic [PRE_W-1:0]  pre_q;

  dither_seq #(
    .TW_W(TW_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W), .SEL_LAT(SEL_LAT)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .int_in  (tune_int),
    .frac_in (tune_frac),
    .pre_in  (prescale),
    .run     (run),
    .frac_q  (frac_q),
    .pre_q   (pre_q),
    .word_lo (word_lo),
    .word_hi (word_hi),
    .word_wr (word_wr)
  );

  dither_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .period_m1 (pre_q),
    .tick      (tick)
  );

  // a load forces the lower register at once; the pattern stays parked until run
  assign acc_clr = load | ~run;

  dither_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .tick  (tick),
    .frac  (frac_q),
    .sel   (sel_hi)
  );

  // R2: the upper register is never selected while an update is in flight
  p_sel_low_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sel_hi);
  // R2: a load always parks select low on the next cycle
  p_load_parks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !sel_hi);
  // R8: the tuning words move only together with the write strobe
  p_words_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_wr |-> ($stable(word_lo) && $stable(word_hi)));
endmodule

// File: tb/dither_ctrl_tb.sv
`timescale 1ns/1ps
module dither_ctrl_tb;
  localparam int TW_W = 16, FRAC_W = 4, PRE_W = 4, SEL_LAT = 6;
  localparam int FMOD = 1 << FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [TW_W-1:0]   tune_int = '0;
  logic [FRAC_W-1:0] tune_frac = '0;
  logic [PRE_W-1:0]  prescale = '0;
  logic [TW_W-1:0]   word_lo, word_hi;
  logic              word_wr, sel_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dither_ctrl #(.TW_W(TW_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W), .SEL_LAT(SEL_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .tune_int(tune_int), .tune_frac(tune_frac),
    .prescale(prescale), .word_lo(word_lo), .word_hi(word_hi), .word_wr(word_wr),
    .sel_hi(sel_hi));

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // from the negedge where load is high up to the first cycle of run
  task automatic load_tail(input int iw);
    @(negedge clk); load = 1'b0;
    chk(sel_hi == 1'b0, "R2", sel_hi, 0, "sel after load edge");
    for (int i = 1; i < SEL_LAT; i++) begin
      @(negedge clk);
      chk(word_wr == 1'b0, "R3", word_wr, 0, "early write");
      chk(sel_hi == 1'b0, "R2", sel_hi, 0, "sel during hold");
    end
    @(negedge clk);
    chk(word_wr == 1'b1, "R3", word_wr, 1, "write strobe");
    chk(int'(word_lo) == (iw & 16'hFFFF), "R3", int'(word_lo), iw & 16'hFFFF, "lower word");
    chk(int'(word_hi) == ((iw + 1) & 16'hFFFF), "R3", int'(word_hi), (iw + 1) & 16'hFFFF, "upper word");
    chk(sel_hi == 1'b0, "R2", sel_hi, 0, "sel at write");
    @(negedge clk);
    chk(word_wr == 1'b0, "R3", word_wr, 0, "strobe width");
    chk(sel_hi == 1'b0, "R2", sel_hi, 0, "sel at run start");
  endtask

  task automatic run_pattern(input int iw, input int f, input int p, input int nticks, input bit scramble);
    int win_a = 0;
    int win_b = 0;
    int lows = 0;
    for (int c = 1; c <= nticks * (p + 1); c++) begin
      int k, e;
      @(negedge clk);
      k = c / (p + 1);
      e = (k == 0) ? 0 : ((k * f) >> FRAC_W) - (((k - 1) * f) >> FRAC_W);
      chk(int'(sel_hi) == e, (k == 0) ? "R4" : "R5", sel_hi, e, "select pattern");
      chk(int'(word_lo) == (iw & 16'hFFFF), "R8", int'(word_lo), iw & 16'hFFFF, "lower word held");
      if (c % (p + 1) == 0) begin
        if (k >= 1 && k <= FMOD) begin
          win_a += int'(sel_hi);
          lows += (sel_hi ? 0 : 1);
        end
        if (k >= 5 && k < 5 + FMOD) win_b += int'(sel_hi);
      end
      if (scramble) begin
        tune_int  = TW_W'($urandom);
        tune_frac = FRAC_W'($urandom);
        prescale  = PRE_W'($urandom);
      end
    end
    if (nticks >= FMOD + 4) begin
      chk(win_a == f, "R6", win_a, f, "window from tick 1");
      chk(win_b == f, "R6", win_b, f, "window from tick 5");
      if (f == 0)        chk(win_a == 0, "R7", win_a, 0, "zero fraction");
      if (f == FMOD - 1) chk(lows == 1, "R7", lows, 1, "max fraction low ticks");
    end
  endtask

  task automatic run_case(input int iw, input int f, input int p, input int nticks, input bit scramble);
    @(negedge clk);
    tune_int = TW_W'(iw); tune_frac = FRAC_W'(f); prescale = PRE_W'(p); load = 1'b1;
    load_tail(iw);
    run_pattern(iw, f, p, nticks, scramble);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(sel_hi == 1'b0, "R1", sel_hi, 0, "reset sel");
    chk(word_lo == '0, "R1", int'(word_lo), 0, "reset lower word");
    chk(int'(word_hi) == 1, "R1", int'(word_hi), 1, "reset upper word");
    chk(word_wr == 1'b0, "R1", word_wr, 0, "reset strobe");
    tune_frac = '1; prescale = '0;
    repeat (20) begin
      @(negedge clk);
      chk(sel_hi == 1'b0, "R1", sel_hi, 0, "idle sel without load");
    end

    // exhaustive fractions at several update rates (R4 R5 R6 R7)
    for (int f = 0; f < FMOD; f++) run_case(f * 1000 + 7, f, 0, FMOD + 8, 1'b0);
    for (int f = 0; f < FMOD; f++) run_case(f * 313 + 2, f, 2, FMOD + 8, 1'b0);
    run_case(4242, 5, 15, FMOD + 8, 1'b0);
    run_case(99, 11, 1, FMOD + 8, 1'b0);

    // R8: inputs toggled without a load are ignored
    run_case(1234, 9, 1, FMOD + 8, 1'b1);

    // R3: upper word wraps at the top of the range
    run_case(16'hFFFF, 3, 0, 8, 1'b0);

    // R9: a load during the hold interval restarts the update
    @(negedge clk);
    tune_int = TW_W'(500); tune_frac = FRAC_W'(2); prescale = '0; load = 1'b1;
    @(negedge clk); load = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(word_wr == 1'b0, "R9", word_wr, 0, "no write before relaunch");
    end
    tune_int = TW_W'(777); tune_frac = FRAC_W'(13); prescale = PRE_W'(1); load = 1'b1;
    load_tail(777);
    chk(int'(word_lo) == 777, "R9", int'(word_lo), 777, "latest word applied");
    run_pattern(777, 13, 1, FMOD + 8, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule